// File: doc/BRIEF.md
# Reset Cause and Soft Reset Request Register

This block is a single 32-bit control and status register that keeps track of why the system was last reset. Software can also use it to ask for a reset. It sits at one word of a simple register bus. Five bits in the top of the word have meaning: one cause bit for a first power-up, two request bits for software, and two cause bits for the reset buttons. Writing a request bit asks for either a power-on style reset or an externally-initiated (XIR) style reset. The request leaves the block as a one-clock pulse. The system reset logic acts on that pulse.

The system reset logic signals each reset that happens through a reset-event input. An internal saturating counter counts these events. The counter tells the first power-on reset apart from later resets. Only when the count is zero does a reset event reload the register with the power-on cause alone. A software power-on request sets the count back to zero, so the reset that follows is reported as a power-on. Button events come in as already-debounced pulses and set their cause bits directly.

Top module: `rst_cause_csr`

## Requirements
- R1: After `rst_n` is deasserted, the register reads 0x00000000, both request outputs are low, and the reset-event count is zero.
- R2: The register accepts writes and returns data only when `bus_addr` with its two low bits dropped equals BASE_ADDR+4 (0xF024 by default). A read at any other address returns zero. A write at any other address leaves the register unchanged.
- R3: The cause bits 31 (power-on), 28 (button power-on) and 27 (button XIR) are write-one-to-clear. Writing 1 to one of them clears it, and writing 0 leaves it as it was.
- R4: The request bits 30 (soft power-on) and 29 (soft XIR) are set by writing 1. Writing 0 to them leaves them as they were.
- R5: Bits 26:0 always read as zero, whatever value is written.
- R6: A write with bit 30 set makes `soft_por_req` high for exactly the one cycle after the write edge. It also sets the reset count to zero, so the next reset event reloads the power-on cause.
- R7: A write with bit 29 set and bit 30 clear makes `soft_xir_req` high for exactly the one cycle after the write edge. It leaves the reset count unchanged.
- R8: A write with both bit 30 and bit 29 set pulses only `soft_por_req`. The two request outputs are never high together.
- R9: A reset event while the count is zero loads the register with exactly 0x80000000. A reset event while the count is nonzero leaves the register unchanged. Every reset event increments the count.
- R10: The reset count saturates at 2^CNT_W-1. Any number of further reset events never causes another power-on reload.
- R11: A high `btn_por_pulse` sets bit 28 and a high `btn_xir_pulse` sets bit 27. A set wins over a write-one-to-clear of the same bit in the same cycle.
- R12: In a cycle where `rst_event` is high, bus writes and button pulses are ignored and neither request output pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the block's own state |
| rst_event | input | 1 | One-cycle pulse from the system reset logic marking a system reset |
| btn_por_pulse | input | 1 | Debounced power-on button event |
| btn_xir_pulse | input | 1 | Debounced XIR button event |
| bus_sel | input | 1 | Register bus access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| soft_por_req | output | 1 | One-cycle soft power-on reset request |
| soft_xir_req | output | 1 | One-cycle soft XIR reset request |

## Verification
The bench builds the block with CNT_W=2, so the reset count saturates after three reset events. The saturation case and the no-wrap case (R10) can then be reached in a few cycles instead of thousands. ADDR_W and BASE_ADDR keep their defaults. This lets the bench aim directed accesses at the selected word, at the unselected word beside it, and at unrelated addresses. Random traffic then mixes writes, button pulses and reset events, including ones that collide in the same cycle.

// File: rtl/rcsr_pkg.sv
package rcsr_pkg;
    localparam int CSR_W  = 32;
    localparam int B_POR  = 31;
    localparam int B_SPOR = 30;
    localparam int B_SXIR = 29;
    localparam int B_BPOR = 28;
    localparam int B_BXIR = 27;

    localparam logic [CSR_W-1:0] M_LIVE = 32'hF800_0000;
    localparam logic [CSR_W-1:0] M_W1C  = 32'h9800_0000;
    localparam logic [CSR_W-1:0] M_W1S  = 32'h6000_0000;
    localparam logic [CSR_W-1:0] V_POR  = 32'h8000_0000;

    typedef struct packed {
        logic [CSR_W-1:0] csr;
        logic             por_req;
        logic             xir_req;
    } rcsr_state_t;
endpackage

// File: rtl/rcsr_decode.sv
module rcsr_decode #(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int HI_W = ADDR_W - 3;
    logic [HI_W-1:0] base_hi;
    assign base_hi = BASE_ADDR[ADDR_W-1:3];
    // Only the upper word of the 8-byte window is live.
    assign hit = (addr[ADDR_W-1:3] == base_hi) && addr[2];
endmodule

// File: rtl/rcsr_event_count.sv
module rcsr_event_count #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic clr,
    output logic is_zero
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc && cnt_q != CNT_MAX)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign is_zero = (cnt_q == '0);

    // R10: a saturated count never wraps back to zero
    p_no_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));
    // R6: a clear leaves the count at zero
    p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> is_zero);
endmodule

// File: rtl/rst_cause_csr.sv
module rst_cause_csr
    import rcsr_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
    parameter int                CNT_W     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_event,
    input  logic              btn_por_pulse,
    input  logic              btn_xir_pulse,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CSR_W-1:0]  bus_wdata,
    output logic [CSR_W-1:0]  bus_rdata,
    output logic              soft_por_req,
    output logic              soft_xir_req
);
    rcsr_state_t      st_d, st_q;
    logic             addr_hit;
    logic             wr_hit;
    logic             cnt_zero;
    logic             cnt_clr;
    logic [CSR_W-1:0] wv;

    rcsr_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_decode (
        .addr (bus_addr),
        .hit  (addr_hit)
    );

    assign wr_hit  = bus_sel && bus_wr && addr_hit && !rst_event;
    assign wv      = bus_wdata & M_LIVE;
    assign cnt_clr = wr_hit && wv[B_SPOR];

    rcsr_event_count #(.CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (rst_event),
        .clr     (cnt_clr),
        .is_zero (cnt_zero)
    );

    always_comb begin
        st_d         = st_q;
        st_d.por_req = 1'b0;
        st_d.xir_req = 1'b0;
        if (rst_event) begin
            if (cnt_zero) st_d.csr = V_POR;
        end else begin
            if (wr_hit) begin
                st_d.csr     = (st_q.csr & ~(wv & M_W1C)) | (wv & M_W1S);
                st_d.por_req = wv[B_SPOR];
                st_d.xir_req = wv[B_SXIR] && !wv[B_SPOR];
            end
            if (btn_por_pulse) st_d.csr[B_BPOR] = 1'b1;
            if (btn_xir_pulse) st_d.csr[B_BXIR] = 1'b1;
        end
        st_d.csr = st_d.csr & M_LIVE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = (bus_sel && !bus_wr && addr_hit) ? st_q.csr : '0;
    assign soft_por_req = st_q.por_req;
    assign soft_xir_req = st_q.xir_req;

    // R8: the two requests never pulse together
    p_req_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(soft_por_req && soft_xir_req));
    // R5: unused bits stay zero
    p_low_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.csr[26:0] == '0);
    // R9: first reset event reloads the power-on cause only
    p_por_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event && cnt_zero) |=> (st_q.csr == V_POR));
    // R11: a button pulse leaves its cause bit set
    p_btn_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (btn_por_pulse && !rst_event) |=> st_q.csr[B_BPOR]);
    // R4: a set request bit survives any bus write
    p_req_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.csr[B_SPOR] && !rst_event) |=> st_q.csr[B_SPOR]);
    // R6: a power-on request pulse follows a write of bit 30 to the live word
    p_por_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        soft_por_req |-> $past(bus_sel && bus_wr && addr_hit && bus_wdata[B_SPOR] && !rst_event));
    // R12: a reset event suppresses request pulses
    p_evt_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rst_event |=> !(soft_por_req || soft_xir_req));
endmodule

// File: tb/test_rst_cause_csr.sv
`timescale 1ns/100ps
module test_rst_cause_csr;
    localparam int CNT_W   = 2;
    localparam int CNT_MAX = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_event = 1'b0;
    logic        btn_por_pulse = 1'b0;
    logic        btn_xir_pulse = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        soft_por_req;
    logic        soft_xir_req;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_reg = '0;
    int          exp_cnt = 0;
    logic        exp_por = 1'b0;
    logic        exp_xir = 1'b0;

    always #2 clk = ~clk;

    rst_cause_csr #(.CNT_W(CNT_W)) i_rst_cause_csr (
        .clk(clk), .rst_n(rst_n), .rst_event(rst_event),
        .btn_por_pulse(btn_por_pulse), .btn_xir_pulse(btn_xir_pulse),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .soft_por_req(soft_por_req), .soft_xir_req(soft_xir_req)
    );

    function automatic logic is_live(input logic [15:0] a);
        return (a & 16'hFFFC) == 16'hF024;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model update applied for the edge that follows the drive.
    task automatic model(input logic sel, input logic wr, input logic [15:0] a,
                         input logic [31:0] d, input logic bp, input logic bx, input logic ev);
        logic [31:0] w;
        exp_por = 1'b0;
        exp_xir = 1'b0;
        if (ev) begin
            if (exp_cnt == 0) exp_reg = 32'h8000_0000;
            if (exp_cnt < CNT_MAX) exp_cnt++;
        end else begin
            if (sel && wr && is_live(a)) begin
                w = d & 32'hF800_0000;
                exp_reg = (exp_reg & ~(w & 32'h9800_0000)) | (w & 32'h6000_0000);
                exp_por = w[30];
                exp_xir = w[29] & ~w[30];
                if (w[30]) exp_cnt = 0;
            end
            if (bp) exp_reg[28] = 1'b1;
            if (bx) exp_reg[27] = 1'b1;
        end
    endtask

    task automatic step(input string tag, input logic sel, input logic wr,
                        input logic [15:0] a, input logic [31:0] d,
                        input logic bp, input logic bx, input logic ev);
        @(negedge clk);
        bus_sel = sel; bus_wr = wr; bus_addr = a; bus_wdata = d;
        btn_por_pulse = bp; btn_xir_pulse = bx; rst_event = ev;
        model(sel, wr, a, d, bp, bx, ev);
        @(posedge clk);
        #0.5;
        btn_por_pulse = 1'b0; btn_xir_pulse = 1'b0; rst_event = 1'b0;
        check({tag, " por_req"}, {31'd0, soft_por_req}, {31'd0, exp_por});
        check({tag, " xir_req"}, {31'd0, soft_xir_req}, {31'd0, exp_xir});
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'hF024;
        #0.5;
        check({tag, " rdata"}, bus_rdata, exp_reg);
    endtask

    task automatic wr(input string tag, input logic [15:0] a, input logic [31:0] d);
        step(tag, 1'b1, 1'b1, a, d, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic evt(input string tag);
        step(tag, 1'b0, 1'b0, 16'h0, 32'h0, 1'b0, 1'b0, 1'b1);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #0.5;
        bus_sel = 1'b1; bus_addr = 16'hF024; #0.2;
        check("R1 reset rdata", bus_rdata, 32'h0);
        check("R1 reset pulses", {30'd0, soft_por_req, soft_xir_req}, 32'h0);

        evt("R9 first event loads por");
        evt("R9 second event no reload");
        wr("R3 w1c por cause", 16'hF024, 32'h8000_0000);
        evt("R9 nonzero count leaves reg");
        wr("R2 other word ignored", 16'hF020, 32'hFFFF_FFFF);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'hF020; #0.5;
        check("R2 other word reads zero", bus_rdata, 32'h0);
        bus_addr = 16'h1024; #0.5;
        check("R2 far address reads zero", bus_rdata, 32'h0);
        wr("R8 both requests", 16'hF024, 32'hFFFF_FFFF);
        wr("R5 low bits zero", 16'hF027, 32'h07FF_FFFF);
        wr("R4 write zero keeps req", 16'hF024, 32'h0);
        evt("R6 count zeroed then reload");
        wr("R3 clear por", 16'hF024, 32'h8000_0000);
        wr("R7 xir only", 16'hF024, 32'h2000_0000);
        evt("R7 count kept no reload");
        step("R11 button set", 1'b0, 1'b0, 16'h0, 32'h0, 1'b1, 1'b1, 1'b0);
        step("R11 set wins over clear", 1'b1, 1'b1, 16'hF024, 32'h1800_0000, 1'b1, 1'b0, 1'b0);
        wr("R3 w1c buttons", 16'hF024, 32'h1800_0000);
        step("R12 event beats write", 1'b1, 1'b1, 16'hF024, 32'hF800_0000, 1'b1, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) evt("R10 saturation no reload");

        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            logic [31:0] d;
            case ($urandom % 4)
                0, 1: a = 16'hF024 | 16'($urandom % 4);
                2:    a = 16'hF020 | 16'($urandom % 4);
                default: a = 16'($urandom);
            endcase
            d = $urandom;
            if (($urandom % 4) != 0) d[30] = 1'b0;
            step("R3 R4 R6 R7 R9 R11 R12 random", 1'($urandom % 2), 1'($urandom % 3 != 0), a, d,
                 1'($urandom % 8 == 0), 1'($urandom % 8 == 0), 1'($urandom % 12 == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule